// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a memory-mapped master for the two-wire PHY management bus. A host places a complete management frame in one 32-bit word and writes it to the frame register. The block then drives a serial transaction on the management clock and data lines: a run of ones as a preamble, followed by the frame word, most significant bit first. When the frame is a read, the block lets go of the data line before the PHY's turnaround and data bits. It collects the sixteen bits the PHY returns and puts them in the low half of the frame register.

Completion is reported by a done bit in an event register. Software clears that bit by writing one to it. A mask register gates the bit onto an interrupt output. With a zero mask the host polls. A speed register sets the management clock divider. A control register holds a self-clearing soft reset bit. The register port is a plain synchronous port: a write strobe, a word address, write data, and read data that is decoded combinationally.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: Once the preamble is done, the 32 bits of the frame word go out on `mdio_o` MSB first. The word is laid out as start [31:30]=01, opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16]=10, data [15:0].
- R2: Each transaction opens with PRE_LEN ones, 32 by default, with `mdio_oe` high.
- R3: `mdc` has a period of twice the divider value in system clocks, high and low for the same number of clocks. It stays low when no transaction is running and while the divider is zero, and a transaction makes no progress while the divider is zero.
- R4: `mdio_o` changes only in the clock after a falling edge of `mdc`, and the block samples `mdio_i` on the rising edge of `mdc`.
- R5: For opcode 10 (read), `mdio_oe` goes low from the second turnaround bit through the last data bit. For opcode 01 (write), `mdio_oe` stays high for the whole frame. `mdio_oe` is low when the block is idle.
- R6: When a read finishes, the 16 bits taken from the PHY replace frame register bits [15:0], and bits [31:16] keep their value. When a write finishes, the frame register is left as it was.
- R7: The clock after the transaction ends, event register bit 0 (done) goes to 1. Writing 1 to that bit clears it, and writing 0 has no effect.
- R8: `irq` equals event bit 0 AND mask register bit 0. A zero mask keeps `irq` low.
- R9: A write to the frame register has no effect while a transaction is running or while its completion is still being recorded.
- R10: Writing 1 to control bit 0 starts a soft reset. During the soft reset control bit 0 reads 1 for RST_CYCLES clocks and then clears by itself. The soft reset sets every register to 0 and abandons any transaction that is running.
- R11: The speed register holds the divider in bits [6:1]. The other speed bits read 0.
- R12: The register word addresses are control 0, event 1, mask 2, speed 3 and frame 4. Any other address reads 0. Only bit 0 is implemented in the control, event and mask registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, decoded combinationally from reg_addr |
| irq | output | 1 | Masked completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the pad |
| mdio_o | output | 1 | Management data to the pad |
| mdio_oe | output | 1 | Management data output enable |

## Verification
The bench runs read frames and write frames with different PHY and register addresses, at divider values 1, 2 and 3. A wrong bit order, a misplaced preamble length or a wrong clock ratio each shows up as a per-clock mismatch on `mdc` or `mdio_o`.

Two reads return different data patterns (A5C3, then 0001), which catches a shifted or reversed capture. A write that follows a read tells apart frames that release the line from frames that keep driving it.

The same write frame doubles as a busy-time overwrite attempt. A divider of zero is paired with a soft reset, which shows that a stalled transaction is abandoned and every register goes back to zero.

// File: rtl/mdio_fc_pkg.sv
package mdio_fc_pkg;
   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_EVT   = 3'd1;
   localparam logic [2:0] A_MASK  = 3'd2;
   localparam logic [2:0] A_SPD   = 3'd3;
   localparam logic [2:0] A_FRAME = 3'd4;

   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   function automatic logic frame_is_read(input logic [31:0] w);
      return w[29:28] == OP_RD;
   endfunction
endpackage

// File: rtl/mdio_fc_clkgen.sv
module mdio_fc_clkgen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] cnt;
   logic             mdc_q;
   logic             div_ok;
   logic             hit;

   assign div_ok = (div != '0);
   assign hit    = run && div_ok && (cnt >= div - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         mdc_q <= 1'b0;
      end else if (clr || !run || !div_ok) begin
         cnt   <= '0;
         mdc_q <= 1'b0;
      end else if (hit) begin
         cnt   <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign mdc  = mdc_q;
   assign rise = hit && !mdc_q;
   assign fall = hit && mdc_q;
endmodule

// File: rtl/mdio_fc_seq.sv
module mdio_fc_seq
   import mdio_fc_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        start,
   input  logic [31:0] word,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdio_i,
   output logic        busy,
   output logic        done,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic [15:0] rd_data
);
   localparam int TOT   = PRE_LEN + 32;
   localparam int IDX_W = $clog2(TOT);
   localparam int LAST  = TOT - 1;
   localparam int REL   = PRE_LEN + 15;
   localparam int DAT0  = PRE_LEN + 16;

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] fpos;
   logic [31:0]      word_q;
   logic [15:0]      cap;
   logic             busy_q;
   logic             done_q;
   logic             cur_bit;
   logic             is_rd;

   assign fpos  = IDX_W'(LAST) - idx;
   assign is_rd = frame_is_read(word_q);

   generate
      if (PRE_LEN > 0) begin : g_pre
         assign cur_bit = (idx < IDX_W'(PRE_LEN)) ? 1'b1 : word_q[fpos[4:0]];
      end else begin : g_nopre
         assign cur_bit = word_q[fpos[4:0]];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         word_q <= '0;
         cap    <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (clr) begin
         idx    <= '0;
         word_q <= '0;
         cap    <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               idx    <= '0;
               word_q <= word;
               cap    <= '0;
            end
         end else begin
            if (rise && idx >= IDX_W'(DAT0)) begin
               cap <= {cap[14:0], mdio_i};
            end
            if (fall) begin
               if (idx == IDX_W'(LAST)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign mdio_o  = busy_q ? cur_bit : 1'b1;
   assign mdio_oe = busy_q && !(is_rd && idx >= IDX_W'(REL));
   assign rd_data = cap;
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
   import mdio_fc_pkg::*;
#(
   parameter int DIV_W      = 6,
   parameter int DIV_LSB    = 1,
   parameter int PRE_LEN    = 32,
   parameter int RST_CYCLES = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq,
   output logic        mdc,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe
);
   localparam int RST_W = $clog2(RST_CYCLES + 1);

   generate
      if (DIV_W < 1 || DIV_LSB + DIV_W > 32) begin : g_bad_div
         $error("divider field does not fit the speed register");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("soft reset must last at least one cycle");
      end
      if (PRE_LEN < 0) begin : g_bad_pre
         $error("preamble length cannot be negative");
      end
   endgenerate

   logic [RST_W-1:0] srst_cnt;
   logic             clr;
   logic             evt_done;
   logic             msk_done;
   logic [DIV_W-1:0] div_q;
   logic [31:0]      frame_q;
   logic             seq_busy;
   logic             seq_done;
   logic [15:0]      seq_data;
   logic             mdc_rise;
   logic             mdc_fall;
   logic             wr_ok;
   logic             start;

   assign clr   = (srst_cnt != '0);
   assign wr_ok = reg_wr && !clr;
   assign start = wr_ok && (reg_addr == A_FRAME) && !seq_busy && !seq_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_cnt <= '0;
         evt_done <= 1'b0;
         msk_done <= 1'b0;
         div_q    <= '0;
         frame_q  <= '0;
      end else if (clr) begin
         srst_cnt <= srst_cnt - 1'b1;
         evt_done <= 1'b0;
         msk_done <= 1'b0;
         div_q    <= '0;
         frame_q  <= '0;
      end else begin
         if (wr_ok && reg_addr == A_CTRL && reg_wdata[0]) begin
            srst_cnt <= RST_W'(RST_CYCLES);
         end
         if (seq_done) begin
            evt_done <= 1'b1;
         end else if (wr_ok && reg_addr == A_EVT && reg_wdata[0]) begin
            evt_done <= 1'b0;
         end
         if (wr_ok && reg_addr == A_MASK) begin
            msk_done <= reg_wdata[0];
         end
         if (wr_ok && reg_addr == A_SPD) begin
            div_q <= reg_wdata[DIV_LSB +: DIV_W];
         end
         if (start) begin
            frame_q <= reg_wdata;
         end else if (seq_done && frame_is_read(frame_q)) begin
            frame_q[15:0] <= seq_data;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata[0] = clr;
         A_EVT:   reg_rdata[0] = evt_done;
         A_MASK:  reg_rdata[0] = msk_done;
         A_SPD:   reg_rdata[DIV_LSB +: DIV_W] = div_q;
         A_FRAME: reg_rdata = frame_q;
         default: reg_rdata = '0;
      endcase
   end

   assign irq = evt_done && msk_done;

   mdio_fc_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .run   (seq_busy),
      .div   (div_q),
      .mdc   (mdc),
      .rise  (mdc_rise),
      .fall  (mdc_fall)
   );

   mdio_fc_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .start   (start),
      .word    (reg_wdata),
      .rise    (mdc_rise),
      .fall    (mdc_fall),
      .mdio_i  (mdio_i),
      .busy    (seq_busy),
      .done    (seq_done),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe),
      .rd_data (seq_data)
   );
endmodule

// File: rtl/mdio_fc_chk.sv
module mdio_fc_chk #(
   parameter int DIV_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mdc,
   input logic             mdio_o,
   input logic             mdio_oe,
   input logic             irq,
   input logic             busy,
   input logic             done,
   input logic             evt,
   input logic             msk,
   input logic [DIV_W-1:0] div,
   input logic [31:0]      frame
);
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);  // R5
   AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);  // R3
   AST_ZERO_DIV_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (div == '0 && $past(div) == '0) |-> !mdc);  // R3
   AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> $stable(mdio_o));  // R4
   AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !msk |-> !irq);  // R8
   AST_DONE_SETS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> evt);  // R7
   AST_FRAME_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(frame));  // R9
endmodule

bind mdio_frame_ctrl mdio_fc_chk #(.DIV_W(DIV_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .irq     (irq),
   .busy    (seq_busy),
   .done    (seq_done),
   .evt     (evt_done),
   .msk     (msk_done),
   .div     (div_q),
   .frame   (frame_q)
);

// File: tb/tb_mdio_frame_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_frame_ctrl;
   localparam int PRE  = 32;
   localparam int TOT  = PRE + 32;
   localparam int RSTC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, mdc, mdio_i, mdio_o, mdio_oe;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [15:0] resp = 16'h0000;

   always #2.5 clk = ~clk;

   mdio_frame_ctrl #(.PRE_LEN(PRE), .RST_CYCLES(RSTC)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc),
      .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

   // behavioural reference model
   int          m_srst, m_div, m_tog, m_c;
   logic        m_ev, m_mk, m_busy, m_pend;
   logic [31:0] m_frame;

   task automatic m_clear();
      m_ev = 0; m_mk = 0; m_div = 0; m_frame = '0;
      m_busy = 0; m_pend = 0; m_tog = 0; m_c = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_srst = 0;
         m_clear();
      end else if (m_srst > 0) begin
         m_srst = m_srst - 1;
         m_clear();
      end else begin
         automatic logic pend_now = m_pend;
         automatic logic busy_now = m_busy;
         m_pend = 0;
         if (m_busy && m_div != 0) begin
            m_c = m_c + 1;
            if (m_c >= m_div) begin
               m_c = 0;
               m_tog = m_tog + 1;
               if (m_tog == 2 * TOT) begin
                  m_busy = 0;
                  m_pend = 1;
               end
            end
         end
         if (pend_now) begin
            m_ev = 1;
            if (m_frame[29:28] == 2'b10) m_frame[15:0] = resp;
         end else if (reg_wr && reg_addr == 3'd1 && reg_wdata[0]) begin
            m_ev = 0;
         end
         if (reg_wr) begin
            case (reg_addr)
               3'd0: if (reg_wdata[0]) m_srst = RSTC;
               3'd2: m_mk = reg_wdata[0];
               3'd3: m_div = int'(reg_wdata[6:1]);
               3'd4: if (!busy_now && !pend_now) begin
                  m_frame = reg_wdata; m_busy = 1; m_tog = 0; m_c = 0;
               end
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison and PHY responder
   always @(negedge clk) begin
      automatic int  k = m_tog / 2;
      automatic logic rd = (m_frame[29:28] == 2'b10);
      automatic logic e_mdc = m_busy && (m_tog % 2 == 1);
      automatic logic e_oe  = m_busy && !(rd && k >= PRE + 15);
      automatic logic e_bit = (k < PRE) ? 1'b1 : m_frame[TOT - 1 - k];
      cycles++;
      if (rst_n) begin
         check("R3 mdc", {31'd0, mdc}, {31'd0, e_mdc});
         check("R5 mdio_oe", {31'd0, mdio_oe}, {31'd0, e_oe});
         if (m_busy && e_oe) check("R1/R2/R4 mdio_o", {31'd0, mdio_o}, {31'd0, e_bit});
         check("R8 irq", {31'd0, irq}, {31'd0, m_ev & m_mk});
      end
      if (m_busy && rd && k >= PRE + 16 && k < TOT) mdio_i = resp[TOT - 1 - k];
      else mdio_i = 1'b1;
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 4000 && !m_ev; i++) @(negedge clk);
   endtask

   initial begin
      mdio_i = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      rd_chk("R10 ctrl reset", 3'd0, 0);
      rd_chk("R7 event reset", 3'd1, 0);
      rd_chk("R8 mask reset", 3'd2, 0);
      rd_chk("R11 speed reset", 3'd3, 0);
      rd_chk("R6 frame reset", 3'd4, 0);
      rd_chk("R12 unmapped", 3'd7, 0);

      // read frame at divider 1
      wr(3'd3, 32'hFFFF_FF83);
      rd_chk("R11 speed field", 3'd3, 32'h0000_0002);
      resp = 16'hA5C3;
      wr(3'd4, 32'h6002_0000 | (32'd5 << 23) | (32'd2 << 18));
      wait_done();
      @(negedge clk);
      rd_chk("R6 read data", 3'd4, 32'h6002_0000 | (32'd5 << 23) | (32'd2 << 18) | 32'hA5C3);
      rd_chk("R7 event set", 3'd1, 1);
      wr(3'd1, 0);
      rd_chk("R7 write 0 keeps", 3'd1, 1);
      wr(3'd1, 1);
      rd_chk("R7 w1c", 3'd1, 0);

      // write frame at divider 3, busy overwrite attempt
      wr(3'd3, 32'd3 << 1);
      wr(3'd4, 32'h5002_1234 | (32'd1 << 23) | (32'd4 << 18));
      repeat (20) @(negedge clk);
      wr(3'd4, 32'h6002_0000);
      rd_chk("R9 busy write ignored", 3'd4, 32'h5002_1234 | (32'd1 << 23) | (32'd4 << 18));
      wr(3'd2, 1);
      wait_done();
      @(negedge clk);
      rd_chk("R6 write frame kept", 3'd4, 32'h5002_1234 | (32'd1 << 23) | (32'd4 << 18));
      check("R8 irq masked on", {31'd0, irq}, 32'd1);
      wr(3'd1, 32'hFFFF_FFFF);
      check("R8 irq after clear", {31'd0, irq}, 32'd0);

      // zero divider stalls, soft reset abandons
      wr(3'd3, 0);
      wr(3'd4, 32'h6002_0000);
      repeat (40) @(negedge clk);
      check("R3 zero div no mdc", {31'd0, mdc}, 32'd0);
      rd_chk("R3 zero div no progress", 3'd1, 0);
      wr(3'd0, 1);
      rd_chk("R10 ctrl reads 1", 3'd0, 1);
      repeat (RSTC + 1) @(negedge clk);
      rd_chk("R10 self clear", 3'd0, 0);
      rd_chk("R10 mask cleared", 3'd2, 0);
      rd_chk("R10 frame cleared", 3'd4, 0);
      check("R10 released", {31'd0, mdio_oe}, 32'd0);

      // second read at divider 2 with another pattern
      wr(3'd3, 32'd2 << 1);
      resp = 16'h0001;
      wr(3'd4, 32'h6002_0000 | (32'd31 << 23) | (32'd1 << 18));
      wait_done();
      @(negedge clk);
      rd_chk("R6 second read", 3'd4, 32'h6002_0000 | (32'd31 << 23) | (32'd1 << 18) | 32'h0001);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule